// File: doc/BRIEF.md
# Video Stream Pixel Position Tracker

This block sits beside a video stream that moves one pixel per transfer over a valid/ready handshake and has no sync or blanking wires. A pixel is taken as transferred on a rising clock edge where both valid and ready are high. A start-of-frame flag rides on the user sideband, and an end-of-line flag rides on the last signal. Only these two flags are used to work out the column and row of each transferred pixel. The block never drives ready, so it cannot stall the stream. Pixel data, valid and the two flags reach the output side through plain wires, with no register in the path.

The first complete frame after reset teaches the block its geometry. The width is the pixel count of that frame's first line. The height is the number of lines that end before the next start of frame. Once this geometry is held, every later line and frame is measured against it. Four single-cycle error pulses report a short line, a long line, a frame that restarts early, and a pixel that comes before any start of frame.

Top module: `vid_pos_tracker`

## Requirements
- R1: A pixel is accepted only on a rising edge with `s_valid` and `s_ready` both high. After each accepted pixel that follows a start of frame, `pos_vld` is high for exactly the next cycle. It stays low otherwise, including during stalls.
- R2: An accepted pixel with `s_sof` high is reported at column 0, row 0.
- R3: After an accepted pixel that has `s_eol` low, the next pixel is reported one column to the right on the same row. After one with `s_eol` high, the next pixel is reported at column 0 on the following row.
- R4: `m_data`, `m_valid`, `m_sof` and `m_eol` equal `s_data`, `s_valid`, `s_sof` and `s_eol` in the same cycle.
- R5: When the second start of frame after reset is accepted, `geom_ok` goes high in the next cycle. `ref_width` then holds the pixel count of the first line of the frame just finished, and `ref_height` holds the number of lines that ended in it. Both stay unchanged until reset.
- R6: While `geom_ok` is high, an accepted pixel with `s_eol` high at a column below `ref_width`-1 raises `err_eol_early` for the next cycle.
- R7: While `geom_ok` is high, the accepted pixel at column `ref_width` raises `err_eol_late` for the next cycle. This happens once per line, whatever that pixel's `s_eol` value.
- R8: While `geom_ok` is high, an accepted `s_sof` that comes after fewer than `ref_height` completed lines raises `err_sof_early` for the next cycle.
- R9: An accepted pixel with `s_sof` low, arriving before any start of frame has been accepted since reset, raises `err_no_sof` for the next cycle and produces no `pos_vld`.
- R10: While `rst` is high at a clock edge, all registered outputs go to zero, and the learned geometry and position are forgotten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Stream valid from the producer |
| s_ready | input | 1 | Stream ready from the consumer (observed only) |
| s_data | input | DATA_W | Pixel word |
| s_sof | input | 1 | Start-of-frame flag (user sideband) |
| s_eol | input | 1 | End-of-line flag (last) |
| m_valid | output | 1 | Pass-through of s_valid |
| m_data | output | DATA_W | Pass-through of s_data |
| m_sof | output | 1 | Pass-through of s_sof |
| m_eol | output | 1 | Pass-through of s_eol |
| pos_vld | output | 1 | Position of last accepted pixel is valid |
| pos_col | output | COL_W | Column of last accepted pixel |
| pos_row | output | ROW_W | Row of last accepted pixel |
| geom_ok | output | 1 | Reference geometry learned |
| ref_width | output | COL_W+1 | Learned pixels per line |
| ref_height | output | ROW_W | Learned lines per frame |
| err_eol_early | output | 1 | Line ended short |
| err_eol_late | output | 1 | Line ran past learned width |
| err_sof_early | output | 1 | Frame restarted before learned height |
| err_no_sof | output | 1 | Pixel seen before any start of frame |

## Verification
The pass-through outputs are combinational, so they are compared in the same cycle while the input is held, before the accepting edge. Every other result is registered once. Position, error pulses and geometry appear in the cycle after the accepting edge. The bench drives inputs on the falling edge and reads these outputs on the next falling edge after the edge that accepted the pixel. Stall cycles are checked at the falling edge after each edge that was not accepted, to confirm that nothing appeared.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_COL_W  = 12;
  localparam int unsigned DEF_ROW_W  = 12;

  typedef struct packed {
    logic early_eol;
    logic late_eol;
    logic early_sof;
    logic no_sof;
  } vpt_err_t;
endpackage

// File: rtl/vpt_pos_count.sv
module vpt_pos_count #(
  parameter int unsigned COL_W = 12,
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             sof,
  input  logic             eol,
  output logic [COL_W-1:0] cur_col,
  output logic [ROW_W-1:0] cur_row,
  output logic [ROW_W-1:0] rows_done,
  output logic             seen_sof
);
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  // coordinates of the pixel on the bus this cycle
  assign cur_col   = sof ? '0 : col_q;
  assign cur_row   = sof ? '0 : row_q;
  assign rows_done = row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q    <= '0;
      row_q    <= '0;
      seen_sof <= 1'b0;
    end else if (acc) begin
      if (sof) seen_sof <= 1'b1;
      if (eol) begin
        col_q <= '0;
        row_q <= cur_row + 1'b1;
      end else begin
        col_q <= cur_col + 1'b1;
        row_q <= cur_row;
      end
    end
  end
endmodule

// File: rtl/vpt_geom_learn.sv
module vpt_geom_learn #(
  parameter int unsigned COL_W = 12,
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             sof,
  input  logic             eol,
  input  logic             seen_sof,
  input  logic [COL_W-1:0] cur_col,
  input  logic [ROW_W-1:0] rows_done,
  output logic             geom_ok,
  output logic [COL_W:0]   ref_w,
  output logic [ROW_W-1:0] ref_h
);
  logic w_got;
  logic close_frame;

  assign close_frame = acc && sof && seen_sof && w_got && (rows_done != '0) && !geom_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      geom_ok <= 1'b0;
      w_got   <= 1'b0;
      ref_w   <= '0;
      ref_h   <= '0;
    end else if (!geom_ok && acc) begin
      if (close_frame) begin
        geom_ok <= 1'b1;
        ref_h   <= rows_done;
      end else begin
        if (sof) w_got <= 1'b0;
        if (eol && (seen_sof || sof) && (!w_got || sof)) begin
          w_got <= 1'b1;
          ref_w <= {1'b0, cur_col} + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vpt_frame_check.sv
module vpt_frame_check #(
  parameter int unsigned COL_W = 12,
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             sof,
  input  logic             eol,
  input  logic             seen_sof,
  input  logic             geom_ok,
  input  logic [COL_W:0]   ref_w,
  input  logic [ROW_W-1:0] ref_h,
  input  logic [COL_W-1:0] cur_col,
  input  logic [ROW_W-1:0] rows_done,
  output vpt_pkg::vpt_err_t err
);
  logic [COL_W:0] col_ext;
  vpt_pkg::vpt_err_t err_d;

  assign col_ext = {1'b0, cur_col};

  always_comb begin
    err_d           = '0;
    err_d.no_sof    = acc && !sof && !seen_sof;
    if (acc && geom_ok) begin
      err_d.early_eol = eol && ((col_ext + 1'b1) < ref_w);
      err_d.late_eol  = (col_ext == ref_w);
      err_d.early_sof = sof && (rows_done < ref_h);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err <= '0;
    else     err <= err_d;
  end
endmodule

// File: rtl/vid_pos_tracker.sv
module vid_pos_tracker #(
  parameter int unsigned DATA_W = vpt_pkg::DEF_DATA_W,
  parameter int unsigned COL_W  = vpt_pkg::DEF_COL_W,
  parameter int unsigned ROW_W  = vpt_pkg::DEF_ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_sof,
  input  logic              s_eol,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic              m_sof,
  output logic              m_eol,
  output logic              pos_vld,
  output logic [COL_W-1:0]  pos_col,
  output logic [ROW_W-1:0]  pos_row,
  output logic              geom_ok,
  output logic [COL_W:0]    ref_width,
  output logic [ROW_W-1:0]  ref_height,
  output logic              err_eol_early,
  output logic              err_eol_late,
  output logic              err_sof_early,
  output logic              err_no_sof
);
  logic             acc;
  logic [COL_W-1:0] cur_col;
  logic [ROW_W-1:0] cur_row;
  logic [ROW_W-1:0] rows_done;
  logic             seen_sof;
  vpt_pkg::vpt_err_t err;

  assign acc     = s_valid && s_ready;
  assign m_valid = s_valid;
  assign m_data  = s_data;
  assign m_sof   = s_sof;
  assign m_eol   = s_eol;

  vpt_pos_count #(.COL_W(COL_W), .ROW_W(ROW_W)) u_cnt (
    .clk(clk), .rst(rst), .acc(acc), .sof(s_sof), .eol(s_eol),
    .cur_col(cur_col), .cur_row(cur_row), .rows_done(rows_done),
    .seen_sof(seen_sof)
  );

  vpt_geom_learn #(.COL_W(COL_W), .ROW_W(ROW_W)) u_geom (
    .clk(clk), .rst(rst), .acc(acc), .sof(s_sof), .eol(s_eol),
    .seen_sof(seen_sof), .cur_col(cur_col), .rows_done(rows_done),
    .geom_ok(geom_ok), .ref_w(ref_width), .ref_h(ref_height)
  );

  vpt_frame_check #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst(rst), .acc(acc), .sof(s_sof), .eol(s_eol),
    .seen_sof(seen_sof), .geom_ok(geom_ok), .ref_w(ref_width),
    .ref_h(ref_height), .cur_col(cur_col), .rows_done(rows_done),
    .err(err)
  );

  assign err_eol_early = err.early_eol;
  assign err_eol_late  = err.late_eol;
  assign err_sof_early = err.early_sof;
  assign err_no_sof    = err.no_sof;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_vld <= 1'b0;
      pos_col <= '0;
      pos_row <= '0;
    end else begin
      pos_vld <= acc && (s_sof || seen_sof);
      if (acc) begin
        pos_col <= cur_col;
        pos_row <= cur_row;
      end
    end
  end
endmodule

// File: rtl/vpt_sva.sv
module vpt_sva #(
  parameter int unsigned COL_W = 12,
  parameter int unsigned ROW_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             s_ready,
  input logic             s_sof,
  input logic             pos_vld,
  input logic [COL_W-1:0] pos_col,
  input logic [ROW_W-1:0] pos_row,
  input logic             geom_ok,
  input logic [COL_W:0]   ref_width,
  input logic [ROW_W-1:0] ref_height,
  input logic             err_eol_early,
  input logic             err_eol_late,
  input logic             err_sof_early,
  input logic             err_no_sof
);
  assert_vld_needs_accept_R1: assert property (@(posedge clk) disable iff (rst)
    pos_vld |-> $past(s_valid && s_ready));

  assert_sof_origin_R2: assert property (@(posedge clk) disable iff (rst)
    (pos_vld && $past(s_sof)) |-> (pos_col == '0 && pos_row == '0));

  assert_geom_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    $past(geom_ok) |-> (geom_ok && $stable(ref_width) && $stable(ref_height)));

  assert_early_late_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(err_eol_early && err_eol_late));

  assert_line_errs_need_geom_R7: assert property (@(posedge clk) disable iff (rst)
    (err_eol_early || err_eol_late || err_sof_early) |-> $past(geom_ok));

  assert_sof_err_needs_accept_R8: assert property (@(posedge clk) disable iff (rst)
    err_sof_early |-> $past(s_valid && s_ready && s_sof));

  assert_no_sof_no_pos_R9: assert property (@(posedge clk) disable iff (rst)
    err_no_sof |-> (!pos_vld && !geom_ok));
endmodule

bind vid_pos_tracker vpt_sva #(.COL_W(COL_W), .ROW_W(ROW_W)) u_sva (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof),
  .pos_vld(pos_vld), .pos_col(pos_col), .pos_row(pos_row),
  .geom_ok(geom_ok), .ref_width(ref_width), .ref_height(ref_height),
  .err_eol_early(err_eol_early), .err_eol_late(err_eol_late),
  .err_sof_early(err_sof_early), .err_no_sof(err_no_sof)
);

// File: tb/sim_vid_pos_tracker.sv
module sim_vid_pos_tracker;
  localparam int DW = 16;
  localparam int CW = 6;
  localparam int RW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0, s_ready = 1'b0, s_sof = 1'b0, s_eol = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic m_valid, m_sof, m_eol;
  logic [DW-1:0] m_data;
  logic pos_vld, geom_ok;
  logic [CW-1:0] pos_col;
  logic [RW-1:0] pos_row;
  logic [CW:0] ref_width;
  logic [RW-1:0] ref_height;
  logic err_eol_early, err_eol_late, err_sof_early, err_no_sof;

  int n_chk = 0;
  int n_bad = 0;
  int beat_no = 0;

  always #10 clk = ~clk;

  vid_pos_tracker #(.DATA_W(DW), .COL_W(CW), .ROW_W(RW)) u0 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eol(s_eol),
    .m_valid(m_valid), .m_data(m_data), .m_sof(m_sof), .m_eol(m_eol),
    .pos_vld(pos_vld), .pos_col(pos_col), .pos_row(pos_row),
    .geom_ok(geom_ok), .ref_width(ref_width), .ref_height(ref_height),
    .err_eol_early(err_eol_early), .err_eol_late(err_eol_late),
    .err_sof_early(err_sof_early), .err_no_sof(err_no_sof)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; s_valid = 1'b0; s_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10", "pos_vld after reset", pos_vld, 0);
    chk("R10", "geom_ok after reset", geom_ok, 0);
    chk("R10", "errors after reset",
        {err_eol_early, err_eol_late, err_sof_early, err_no_sof}, 0);
  endtask

  // one pixel; expectations are for the cycle after the accepting edge
  task automatic beat(input logic sof, input logic eol, input int stall,
                      input int e_vld, input int e_col, input int e_row,
                      input int e_early, input int e_late, input int e_esof,
                      input int e_nosof);
    logic [DW-1:0] d;
    beat_no++;
    d = DW'(beat_no * 37 + 5);
    s_valid = 1'b1; s_sof = sof; s_eol = eol; s_data = d; s_ready = 1'b0;
    for (int k = 0; k < stall; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1", "pos_vld during stall", pos_vld, 0);
    end
    s_ready = 1'b1;
    chk("R4", "m_data", m_data, d);
    chk("R4", "m_flags", {m_valid, m_sof, m_eol}, {1'b1, sof, eol});
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0;
    chk("R1", "pos_vld", pos_vld, e_vld);
    if (e_vld != 0) begin
      chk(sof ? "R2" : "R3", "pos_col", pos_col, e_col);
      chk(sof ? "R2" : "R3", "pos_row", pos_row, e_row);
    end
    chk("R6", "err_eol_early", err_eol_early, e_early);
    chk("R7", "err_eol_late", err_eol_late, e_late);
    chk("R8", "err_sof_early", err_sof_early, e_esof);
    chk("R9", "err_no_sof", err_no_sof, e_nosof);
  endtask

  // clean frame of w x h; ready held low for a few cycles on some beats
  task automatic frame(input int w, input int h);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        beat(r == 0 && c == 0, c == w - 1, (r + c) % 3 == 2 ? 1 : 0,
             1, c, r, 0, 0, 0, 0);
  endtask

  initial begin
    // sweep geometries
    for (int w = 2; w <= 5; w++) begin
      for (int h = 1; h <= 3; h++) begin
        do_reset();
        frame(w, h);
        chk("R5", "geom_ok before 2nd sof", geom_ok, 0);
        frame(w, h);
        chk("R5", "geom_ok", geom_ok, 1);
        chk("R5", "ref_width", ref_width, w);
        chk("R5", "ref_height", ref_height, h);
        frame(w, h);
        chk("R5", "ref_width kept", ref_width, w);
      end
    end
    // ready high, valid low: nothing accepted
    @(negedge clk); s_ready = 1'b1; s_valid = 1'b0;
    @(negedge clk);
    chk("R1", "pos_vld valid low", pos_vld, 0);

    // missing start of frame after reset
    do_reset();
    beat(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    beat(0, 1, 1, 0, 0, 0, 0, 0, 0, 1);
    beat(1, 0, 0, 1, 0, 0, 0, 0, 0, 0);

    // error cases on learned 4 x 3
    do_reset();
    frame(4, 3);
    frame(4, 3);
    chk("R5", "ref_width 4", ref_width, 4);
    // short line at row 0: eol at column 1
    beat(1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    beat(0, 1, 0, 1, 1, 0, 1, 0, 0, 0);
    // long line at row 1: columns 0..5, late at column 4 only
    for (int c = 0; c < 6; c++)
      beat(0, c == 5, 0, 1, c, 1, 0, c == 4 ? 1 : 0, 0, 0);
    // row 2 gets one pixel then frame restarts: only 2 lines done
    beat(0, 0, 0, 1, 0, 2, 0, 0, 0, 0);
    beat(1, 0, 0, 1, 0, 0, 0, 0, 1, 0);
    beat(0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    beat(0, 0, 0, 1, 2, 0, 0, 0, 0, 0);
    beat(0, 1, 0, 1, 3, 0, 0, 0, 0, 0);
    chk("R5", "geom unchanged after errors", {ref_width, ref_height}, {7'd4, 6'd3});
    // reset mid-run forgets geometry
    do_reset();
    chk("R10", "ref_width cleared", ref_width, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule